// File: doc/BRIEF.md
# 8-bit ALU with Held Condition Flags

This block is the arithmetic and logic unit of a small byte-wide processor datapath. Each cycle it takes a register operand, a memory operand and an operation code. It produces the byte result combinationally, together with a mask of the condition flags that the operation would write. When `apply` is high, the selected flags (negative, zero, carry, overflow) are loaded into a flag register on the next rising clock edge. The flags that the operation does not select keep their previous values.

The carry that feeds add, subtract and the rotates is the held carry flag. A chain of operations therefore propagates carry from one operation to the next, as a multi-byte sum or shift needs. Subtraction uses an inverted borrow: a set carry means no borrow. Decimal arithmetic is not provided. Fetching operands and writing the result back are the job of the surrounding datapath.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) gives result = (reg + mem + C) mod 256. C becomes the carry out of bit 7, and the mask is 4'b1111.
- R2: Code 1 (subtract) gives result = (reg - mem - (1 - C)) mod 256. C becomes 1 exactly when no borrow occurs (reg >= mem + 1 - C), and the mask is 4'b1111.
- R3: On add and subtract, V is set when the two effective addends share a sign bit and the result's sign bit differs. For subtract this is the case when reg and mem differ in bit 7 and the result's bit 7 differs from reg's.
- R4: For every operation except compare, a written N takes result bit 7, and a written Z is set exactly when the 8-bit result is zero.
- R5: Codes 2 (AND), 3 (OR), 4 (XOR), 9 (reg + 1), 10 (reg - 1) and 12 (pass reg) produce their result from the register operand and write only N and Z (mask 4'b1100).
- R6: Code 5 (shift left) moves reg bit 7 into C and fills bit 0 with zero. Code 6 (shift right) moves reg bit 0 into C and fills bit 7 with zero. Both use mask 4'b1110.
- R7: Code 7 (rotate left) puts the old C into bit 0 and reg bit 7 into C. Code 8 (rotate right) puts the old C into bit 7 and reg bit 0 into C. Both use mask 4'b1110.
- R8: Code 11 (compare) outputs reg unchanged and uses mask 4'b1110. It sets C when reg >= mem, sets Z when reg == mem, and takes N from bit 7 of (reg - mem) mod 256. V keeps its value.
- R9: `upd_mask` bits are [3]=N, [2]=Z, [1]=C, [0]=V. A flag is written at a rising edge only when `apply` is high and its mask bit is set; otherwise it holds its value.
- R10: While `rst_n` is low, all four flags are cleared to 0.
- R11: Reserved codes 13 to 15 output reg unchanged with mask 4'b0000, so no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| apply | input | 1 | Commit the masked flags at the next rising edge |
| op_code | input | 4 | Operation selector |
| reg_opnd | input | WIDTH | Register operand |
| mem_opnd | input | WIDTH | Memory operand |
| result | output | WIDTH | Combinational result |
| upd_mask | output | 4 | Flags this operation writes, {N,Z,C,V} |
| flag_n | output | 1 | Held negative flag |
| flag_z | output | 1 | Held zero flag |
| flag_c | output | 1 | Held carry flag |
| flag_v | output | 1 | Held overflow flag |

## Verification
Two things meet at the same clock edge. The carry flag is read combinationally as the input of the operation in progress, and that same carry is rewritten at that edge. The bench provokes this with back-to-back add, subtract and rotate operations whose carry-out changes at every step. It also issues operations with a partial mask, or with `apply` low, right after operations that set all four flags; there the update path and the hold path meet in one cycle. A behavioural model checks the result, the mask and each flag against its own carry, cycle by cycle, so a carry taken one cycle too early or too late, or a flag updated outside its mask, shows up as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_AND = 4'd2,  OP_OR  = 4'd3,
      OP_XOR = 4'd4,  OP_SHL = 4'd5,  OP_SHR = 4'd6,  OP_ROL = 4'd7,
      OP_ROR = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_CMP = 4'd11,
      OP_MOV = 4'd12
   } alu_op_e;

   localparam int NFLAGS = 4;
   localparam int FL_N = 3;
   localparam int FL_Z = 2;
   localparam int FL_C = 1;
   localparam int FL_V = 0;

   typedef logic [NFLAGS-1:0] flag_vec_t;

   localparam flag_vec_t MASK_ALL  = 4'b1111;
   localparam flag_vec_t MASK_NZ   = 4'b1100;
   localparam flag_vec_t MASK_NZC  = 4'b1110;
   localparam flag_vec_t MASK_NONE = 4'b0000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   wide;

   // subtraction as a + ~b + carry: carry set means no borrow
   assign b_eff = sub ? ~b : b;
   assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
   assign sum   = wide[MSB:0];
   assign cout  = wide[WIDTH];
   assign ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic             cin,
   input  logic             to_right,
   input  logic             thru_carry,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   localparam int MSB = WIDTH - 1;

   logic fill;
   assign fill = thru_carry & cin;

   always_comb begin
      if (to_right) begin
         res  = {fill, a[MSB:1]};
         cout = a[0];
      end else begin
         res  = {a[MSB-1:0], fill};
         cout = a[MSB];
      end
   end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (sel)
         2'd0:    res = a & b;
         2'd1:    res = a | b;
         default: res = a ^ b;
      endcase
   end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
   import alu8_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  flag_vec_t mask,
   input  flag_vec_t nxt,
   output flag_vec_t q
);
   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                q[i] <= 1'b0;
         else if (en && mask[i])    q[i] <= nxt[i];
      end
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] reg_opnd,
   input  logic [WIDTH-1:0] mem_opnd,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       upd_mask,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu8_core: WIDTH must be at least 2");
   end

   alu_op_e          op;
   flag_vec_t        q, nxt, mask;
   logic [WIDTH-1:0] as_sum, sh_res, bw_res;
   logic             as_cout, as_ovf, sh_cout;
   logic             is_cmp, is_sub;
   logic [1:0]       bw_sel;

   assign op     = alu_op_e'(op_code);
   assign is_cmp = (op == OP_CMP);
   assign is_sub = (op == OP_SUB) || is_cmp;
   assign bw_sel = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;

   alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(reg_opnd), .b(mem_opnd), .cin(is_cmp | q[FL_C]), .sub(is_sub),
      .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
   );

   alu8_shifter #(.WIDTH(WIDTH)) u_shift (
      .a(reg_opnd), .cin(q[FL_C]),
      .to_right((op == OP_SHR) || (op == OP_ROR)),
      .thru_carry((op == OP_ROL) || (op == OP_ROR)),
      .res(sh_res), .cout(sh_cout)
   );

   alu8_bitwise #(.WIDTH(WIDTH)) u_bitw (
      .a(reg_opnd), .b(mem_opnd), .sel(bw_sel), .res(bw_res)
   );

   always_comb begin
      result    = reg_opnd;
      mask      = MASK_NONE;
      nxt[FL_C] = 1'b0;
      nxt[FL_V] = as_ovf;
      unique case (op)
         OP_ADD, OP_SUB: begin
            result = as_sum; mask = MASK_ALL; nxt[FL_C] = as_cout;
         end
         OP_AND, OP_OR, OP_XOR: begin
            result = bw_res; mask = MASK_NZ;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            result = sh_res; mask = MASK_NZC; nxt[FL_C] = sh_cout;
         end
         OP_INC: begin result = reg_opnd + ONE; mask = MASK_NZ; end
         OP_DEC: begin result = reg_opnd - ONE; mask = MASK_NZ; end
         OP_MOV: begin mask = MASK_NZ; end
         OP_CMP: begin mask = MASK_NZC; nxt[FL_C] = as_cout; end
         default: ;
      endcase
      // compare judges the difference, every other op judges its result
      nxt[FL_N] = is_cmp ? as_sum[MSB] : result[MSB];
      nxt[FL_Z] = is_cmp ? (as_sum == '0) : (result == '0);
   end

   alu8_flagreg u_flags (
      .clk(clk), .rst_n(rst_n), .en(apply), .mask(mask), .nxt(nxt), .q(q)
   );

   assign upd_mask = mask;
   assign flag_n   = q[FL_N];
   assign flag_z   = q[FL_Z];
   assign flag_c   = q[FL_C];
   assign flag_v   = q[FL_V];
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             apply,
   input logic [3:0]       op_code,
   input logic [WIDTH-1:0] reg_opnd,
   input logic [WIDTH-1:0] mem_opnd,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       upd_mask,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c,
   input logic             flag_v
);
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable({flag_n, flag_z, flag_c, flag_v}));

   p_c_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !upd_mask[1]) |=> $stable(flag_c));

   p_v_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !upd_mask[0]) |=> $stable(flag_v));

   p_n_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && upd_mask[3] && op_code != 4'd11) |=> (flag_n == $past(result[WIDTH-1])));

   p_z_res_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && upd_mask[2] && op_code != 4'd11) |=> (flag_z == ($past(result) == '0)));

   p_cmp_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && op_code == 4'd11) |=> (flag_c == ($past(reg_opnd) >= $past(mem_opnd))));

   p_cmp_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd11) |-> (result == reg_opnd));

   p_nz_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code inside {4'd2, 4'd3, 4'd4, 4'd9, 4'd10, 4'd12}) |-> (upd_mask == 4'b1100));

   p_shl_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && op_code == 4'd5) |=> (flag_c == $past(reg_opnd[WIDTH-1])));

   p_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code >= 4'd13) |-> (upd_mask == 4'b0000 && result == reg_opnd));
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .apply(apply), .op_code(op_code),
   .reg_opnd(reg_opnd), .mem_opnd(mem_opnd), .result(result),
   .upd_mask(upd_mask), .flag_n(flag_n), .flag_z(flag_z),
   .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       apply = 1'b0;
   logic [3:0] op_code = 4'd0;
   logic [7:0] reg_opnd = 8'd0;
   logic [7:0] mem_opnd = 8'd0;
   logic [7:0] result;
   logic [3:0] upd_mask;
   logic       flag_n, flag_z, flag_c, flag_v;

   int n_cmp = 0;
   int n_bad = 0;
   int mn = 0, mz = 0, mc = 0, mv = 0;   // model flags

   always #2.5 clk = ~clk;   // 200 MHz

   alu8_core #(.WIDTH(8)) u0 (
      .clk(clk), .rst_n(rst_n), .apply(apply), .op_code(op_code),
      .reg_opnd(reg_opnd), .mem_opnd(mem_opnd), .result(result),
      .upd_mask(upd_mask), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(int op);
      case (op)
         0: return "R1";
         1: return "R2";
         5, 6: return "R6";
         7, 8: return "R7";
         11: return "R8";
         13, 14, 15: return "R11";
         default: return "R5";
      endcase
   endfunction

   // behavioural reference: returns result, mask, and candidate flags
   task automatic model(int op, int r, int m, output int res, output int msk,
                        output int fn, output int fz, output int fc, output int fv);
      int t;
      res = r; msk = 0; fc = mc; fv = mv;
      case (op)
         0: begin t = r + m + mc; res = t % 256; fc = (t > 255);
                  fv = ((r/128) == (m/128)) && ((res/128) != (r/128)); msk = 15; end
         1: begin t = r - m - (1 - mc); res = (t + 512) % 256; fc = (t >= 0);
                  fv = ((r/128) != (m/128)) && ((res/128) != (r/128)); msk = 15; end
         2: begin res = r & m; msk = 12; end
         3: begin res = r | m; msk = 12; end
         4: begin res = r ^ m; msk = 12; end
         5: begin res = (r * 2) % 256; fc = r / 128; msk = 14; end
         6: begin res = r / 2; fc = r % 2; msk = 14; end
         7: begin res = (r * 2) % 256 + mc; fc = r / 128; msk = 14; end
         8: begin res = r / 2 + 128 * mc; fc = r % 2; msk = 14; end
         9: begin res = (r + 1) % 256; msk = 12; end
         10: begin res = (r + 255) % 256; msk = 12; end
         12: begin msk = 12; end
         11: begin res = r; msk = 14; fc = (r >= m); end
         default: ;
      endcase
      if (op == 11) begin
         t = (r - m + 256) % 256;
         fn = t / 128; fz = (r == m);
      end else begin
         fn = res / 128; fz = (res == 0);
      end
   endtask

   task automatic step(bit en, int op, int r, int m);
      int res, msk, fn, fz, fc, fv;
      string tag;
      apply = en; op_code = 4'(op); reg_opnd = 8'(r); mem_opnd = 8'(m);
      #1;
      model(op, r, m, res, msk, fn, fz, fc, fv);
      tag = tag_of(op);
      chk(tag, "result", int'(result), res);
      chk(tag, "mask", int'(upd_mask), msk);
      @(posedge clk);
      if (en) begin
         if (msk & 8) mn = fn;
         if (msk & 4) mz = fz;
         if (msk & 2) mc = fc;
         if (msk & 1) mv = fv;
      end
      #1;
      if (!en) tag = "R9";
      chk(tag, "flag_n", int'(flag_n), mn);
      chk(tag, "flag_z", int'(flag_z), mz);
      chk(tag, "flag_c", int'(flag_c), mc);
      chk(tag, "flag_v", int'(flag_v), mv);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: flags cleared by reset
      chk("R10", "flags", int'({flag_n, flag_z, flag_c, flag_v}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "flags after release", int'({flag_n, flag_z, flag_c, flag_v}), 0);

      // R1/R3: signed overflow, then unsigned carry out to zero
      step(1, 0, 8'h50, 8'h50);
      step(1, 0, 8'hFF, 8'h01);
      step(1, 0, 8'h10, 8'h20);          // R1 carry-in consumed
      // R2/R3: no borrow, borrow, signed overflow
      step(1, 1, 5, 3);
      step(1, 1, 3, 5);
      step(1, 1, 8'h80, 8'h01);
      step(1, 1, 8'h7F, 8'hFF);
      // R5: only N/Z touched, V from previous op must survive
      step(1, 0, 8'h7F, 8'h01);
      step(1, 2, 8'hF0, 8'h0F);
      step(1, 3, 8'h80, 8'h01);
      step(1, 4, 8'hAA, 8'hAA);
      step(1, 9, 8'hFF, 0);
      step(1, 10, 8'h00, 0);
      step(1, 12, 8'h80, 0);
      // R6/R7: shifts and rotates chained through carry
      step(1, 5, 8'h81, 0);
      step(1, 7, 8'h40, 0);
      step(1, 8, 8'h01, 0);
      step(1, 8, 8'h00, 0);
      step(1, 6, 8'h01, 0);
      step(1, 7, 8'h80, 0);
      // R8: equal, below, above, and N from the difference
      step(1, 11, 8'h42, 8'h42);
      step(1, 11, 8'h10, 8'h20);
      step(1, 11, 8'hF0, 8'h01);
      step(1, 11, 8'h01, 8'hF0);
      // R11: reserved codes leave flags alone
      step(1, 13, 8'h00, 8'h55);
      step(1, 14, 8'h80, 8'h55);
      step(1, 15, 8'h33, 8'h55);
      // R9: apply low holds every flag
      step(1, 0, 8'h80, 8'h80);
      step(0, 4, 8'h00, 8'h00);
      step(0, 1, 8'h00, 8'h01);

      for (int i = 0; i < 3000; i++)
         step(($urandom % 8) != 0, int'($urandom % 16),
              int'($urandom % 256), int'($urandom % 256));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule